// File: doc/BRIEF.md
# Selectable-Tap Watchdog Timer

This block is a watchdog counter for a small microcontroller. Software must refresh it at intervals. If no refresh arrives before the selected timeout, the block emits a one-cycle reset pulse and starts counting again from zero. A write-only mode byte sets the behaviour:

- a two-bit tap code that picks one of four timeouts;
- a flag that keeps the counter running while the core is in HALT;
- a flag that keeps it running while the device is in STOP;
- a source bit that picks the counted clock.

The counted clock is either the system clock itself or a tick from a slow on-board RC oscillator. The RC tick arrives asynchronously and passes through a synchronizer first. With the RC source, the four tap codes stand for nominal timeouts of 5, 10, 20 and 80 ms. Their ratio is 1:2:4:16, which is the same ratio as the system-clock taps.

Both tap bases are parameters: `SYS_TAP0` system cycles and `RC_TAP0` RC ticks for code 00. Codes 01, 10 and 11 scale the base by 2, 4 and 16.

Top module: `wdog_tap_timer`

## Requirements
- R1: Mode bit 4 = 1 selects the system clock as the counting source. The tap codes in bits 1:0 then give a timeout of 128, 256, 512 or 2048 cycles for codes 00, 01, 10 and 11. The timeout runs from the clock edge that takes a refresh to the edge that raises `wdt_rst`.
- R2: Mode bit 4 = 0 selects the RC source. The same codes then need 16, 32, 64 or 256 RC ticks. Each tick passes through a two-flop synchronizer and advances the counter one edge later. The last tick, sampled at edge A, raises `wdt_rst` at edge A+2.
- R3: The mode byte is loaded on a clock edge where `wr_en` = 1, and it acts from the next cycle. Bits 7:5 of `wr_data` are ignored: writing 0xFC behaves exactly like writing 0x1C.
- R4: After reset the mode byte is 0x0F (RC source, tap 11, HALT and STOP counting both on), the counter is zero and `wdt_rst` is low.
- R5: While `in_halt` = 1 and mode bit 2 = 0, the counter holds its value. With bit 2 = 1, it keeps counting during HALT.
- R6: While `in_stop` = 1 and mode bit 3 = 0, the counter holds its value. With bit 3 = 1, it keeps counting during STOP.
- R7: `refresh` = 1 clears the counter on that edge. If that edge is also the terminal edge, the clear wins and no pulse is emitted.
- R8: `wdt_rst` is high for exactly one cycle. Counting restarts at zero, so a block left unattended pulses again one full timeout later.
- R9: A write whose tap code differs from the current one clears the counter, with no pulse on that edge. A write that keeps the tap code does not disturb the count.
- R10: With the RC source selected and no RC ticks, the counter does not advance, however many system cycles pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rc_tick | input | 1 | Asynchronous tick from the RC oscillator |
| refresh | input | 1 | Watchdog refresh strobe |
| in_halt | input | 1 | Core is in HALT |
| in_stop | input | 1 | Device is in STOP |
| wr_en | input | 1 | Mode byte write strobe |
| wr_data | input | 8 | Mode byte write data |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
Two events can fall on the same edge: the terminal count, and a clear caused by either a refresh or a tap-changing write. The bench provokes this in two ways:

- It lets a 128-cycle timeout run for exactly 127 cycles and then raises `refresh`, so that the refresh lands on the terminal edge.
- It repeats the case with a tap-changing write in place of the refresh.

In both cases the check requires that no pulse appears on that edge and that the next pulse arrives one full new timeout later.

// File: rtl/wdog_pkg.sv
// Package: shared types and helpers for the selectable-tap watchdog.
// Assumes a five-bit stored mode; the upper write bits are dropped elsewhere.
package wdog_pkg;

    // Stored mode fields, MSB first: source, STOP run, HALT run, tap code.
    typedef struct packed {
        logic       src_sys;
        logic       stop_run;
        logic       halt_run;
        logic [1:0] tap;
    } wdog_mode_t;

    localparam logic [4:0] MODE_RST = 5'h0F;
    localparam int         N_TAPS   = 4;

    // Shift applied to a tap base for a given tap code (x1, x2, x4, x16).
    function automatic int tap_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 0;
            2'd1:    return 1;
            2'd2:    return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/wdog_mode_reg.sv
// Module: write-only mode register of the watchdog.
// Stores bits 4:0 of a write. Flags a write whose tap code differs from
// the one held, so that the counter can restart. Assumes wr_data is
// stable around the clock edge.
module wdog_mode_reg
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output wdog_mode_t mode_o,
    output logic       tap_chg_o
);

    wdog_mode_t mode_q;

    // Load the low five bits on a write; the reset value is MODE_RST.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= wdog_mode_t'(MODE_RST);
        end else if (wr_en) begin
            mode_q <= wdog_mode_t'(wr_data[4:0]);
        end
    end

    // Flag a write that changes the tap code.
    always_comb begin
        tap_chg_o = wr_en && (wr_data[1:0] != mode_q.tap);
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/wdog_tick_sync.sv
// Module: multi-flop synchronizer for the asynchronous RC tick.
// The latency equals STAGES clock cycles. Assumes each tick lasts at
// least one system clock period.
module wdog_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic tick_o
);

    logic [STAGES-1:0] sync_q;

    // First stage samples the raw tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q[0] <= 1'b0;
        end else begin
            sync_q[0] <= tick_i;
        end
    end

    // Every further stage re-samples the stage before it.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_q[s] <= 1'b0;
            end else begin
                sync_q[s] <= sync_q[s-1];
            end
        end
    end

    assign tick_o = sync_q[STAGES-1];

endmodule

// File: rtl/wdog_counter.sv
// Module: watchdog count and expiry logic.
// Advances when the source allows it (every cycle for the system clock,
// on tick-high cycles for RC) and neither HALT nor STOP freezes it.
// A clear has priority over expiry. Assumes clear_i merges refresh and
// tap-change events.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int SYS_TAP0 = 128,
    parameter int RC_TAP0  = 16,
    parameter int CNT_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wdog_mode_t       mode_i,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic             halt_i,
    input  logic             stop_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] sys_term [N_TAPS];
    logic [CNT_W-1:0] rc_term  [N_TAPS];
    logic [CNT_W-1:0] term_last;
    logic [CNT_W-1:0] cnt_q;
    logic             run;

    // One terminal value per tap and per source.
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int SH = tap_shift(2'(g));
        assign sys_term[g] = CNT_W'(SYS_TAP0 << SH);
        assign rc_term[g]  = CNT_W'(RC_TAP0 << SH);
    end

    // Pick the last count value of the active tap.
    always_comb begin
        if (mode_i.src_sys) begin
            term_last = sys_term[mode_i.tap] - CNT_W'(1);
        end else begin
            term_last = rc_term[mode_i.tap] - CNT_W'(1);
        end
    end

    // Decide whether this cycle advances the count.
    always_comb begin
        run = (mode_i.src_sys || tick_i)
            && (!halt_i || mode_i.halt_run)
            && (!stop_i || mode_i.stop_run);
    end

    // Count, wrap at the terminal value, and pulse on the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            expire_o <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (clear_i) begin
                cnt_q <= '0;
            end else if (run) begin
                if (cnt_q >= term_last) begin
                    cnt_q    <= '0;
                    expire_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/wdog_tap_timer.sv
// Module: top of the selectable-tap watchdog.
// Joins the mode register, the RC tick synchronizer and the counter.
// Assumes refresh, in_halt, in_stop and the write port are synchronous
// to clk; rc_tick may be asynchronous.
module wdog_tap_timer
    import wdog_pkg::*;
#(
    parameter int SYS_TAP0    = 128,
    parameter int RC_TAP0     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rc_tick,
    input  logic       refresh,
    input  logic       in_halt,
    input  logic       in_stop,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       wdt_rst
);

    localparam int MAX_BASE = (SYS_TAP0 > RC_TAP0) ? SYS_TAP0 : RC_TAP0;
    localparam int CNT_W    = $clog2(MAX_BASE * 16 + 1);

    wdog_mode_t       mode;
    logic             tap_chg;
    logic             tick_s;
    logic             clear;
    logic [CNT_W-1:0] cnt;

    wdog_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .mode_o    (mode),
        .tap_chg_o (tap_chg)
    );

    wdog_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (rc_tick),
        .tick_o (tick_s)
    );

    // Merge the two sources of a counter restart.
    always_comb begin
        clear = refresh || tap_chg;
    end

    wdog_counter #(
        .SYS_TAP0 (SYS_TAP0),
        .RC_TAP0  (RC_TAP0),
        .CNT_W    (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .clear_i  (clear),
        .tick_i   (tick_s),
        .halt_i   (in_halt),
        .stop_i   (in_stop),
        .cnt_o    (cnt),
        .expire_o (wdt_rst)
    );

endmodule

// File: rtl/wdog_tap_timer_checker.sv
// Module: property checker for the watchdog, bound into the top module.
// Observes the ports together with the stored mode and the count.
module wdog_tap_timer_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             refresh,
    input logic             in_halt,
    input logic             in_stop,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             wdt_rst,
    input logic [4:0]       mode_q,
    input logic [CNT_W-1:0] cnt
);

    logic tap_write;
    assign tap_write = wr_en && (wr_data[1:0] != mode_q[1:0]);

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    p_refresh_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (cnt == '0) && !wdt_rst);

    p_tap_write_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tap_write |=> (cnt == '0) && !wdt_rst);

    p_mode_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mode_q == $past(wr_data[4:0]));

    p_halt_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_halt && !mode_q[2] && !refresh && !tap_write) |=> $stable(cnt) && !wdt_rst);

    p_stop_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop && !mode_q[3] && !refresh && !tap_write) |=> $stable(cnt) && !wdt_rst);

endmodule

bind wdog_tap_timer wdog_tap_timer_checker #(.CNT_W(CNT_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .refresh (refresh),
    .in_halt (in_halt),
    .in_stop (in_stop),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wdt_rst (wdt_rst),
    .mode_q  (mode),
    .cnt     (cnt)
);

// File: tb/test_wdog_tap_timer.sv
// Bench: vector table of mode bytes and timeouts, then directed tests.
// All stimulus and sampling happen on the falling clock edge.
module test_wdog_tap_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 8;

    localparam logic [7:0] VMODE [NVEC] = '{
        8'h1C, 8'h1D, 8'h1E, 8'h1F, 8'hFC, 8'h0C, 8'h0D, 8'h0F
    };
    localparam int VCOUNT [NVEC] = '{
        128, 256, 512, 2048, 128, 16, 32, 256
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rc_tick;
    logic       refresh;
    logic       in_halt;
    logic       in_stop;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       wdt_rst;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_tap_timer i_wdog_tap_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .rc_tick (rc_tick),
        .refresh (refresh),
        .in_halt (in_halt),
        .in_stop (in_stop),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wdt_rst (wdt_rst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_refresh();
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
    endtask

    // Expect the pulse exactly n edges from now and not before.
    task automatic expect_after(input int n, input string req);
        int early = 0;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            if (wdt_rst) early++;
        end
        chk(early == 0, req, early, 0);
        @(negedge clk);
        chk(wdt_rst == 1'b1, req, wdt_rst, 1);
    endtask

    // Drive n RC ticks, three cycles each; return the pulse samples seen.
    task automatic rc_ticks(input int n, output int hits, output bit last_hit);
        hits = 0;
        last_hit = 1'b0;
        for (int i = 0; i < n; i++) begin
            rc_tick = 1'b1;
            @(negedge clk);
            rc_tick = 1'b0;
            if (wdt_rst) hits++;
            @(negedge clk);
            if (wdt_rst) hits++;
            @(negedge clk);
            if (wdt_rst) hits++;
            last_hit = wdt_rst;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int  hits;
        bit  lh;
        int  quiet;
        rst_n = 1'b0; rc_tick = 1'b0; refresh = 1'b0;
        in_halt = 1'b0; in_stop = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
        repeat (3) @(negedge clk);
        chk(wdt_rst == 1'b0, "R4 reset low", wdt_rst, 0);
        rst_n = 1'b1;

        // R10 and R4: the default RC source does not count without ticks.
        quiet = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (wdt_rst) quiet++;
        end
        chk(quiet == 0, "R10 no ticks no count", quiet, 0);
        // R4: the default tap 11 needs 256 ticks.
        rc_ticks(256, hits, lh);
        chk(hits == 1 && lh, "R4 default tap 256 ticks", hits, 1);

        // Vector loop covering R1, R2 and R3.
        for (int v = 0; v < NVEC; v++) begin
            write_mode(VMODE[v]);
            do_refresh();
            if (VMODE[v][4]) begin
                expect_after(VCOUNT[v], "R1/R3 sys tap vector");
            end else begin
                rc_ticks(VCOUNT[v], hits, lh);
                chk(hits == 1 && lh, "R2 rc tap vector", hits, 1);
            end
        end

        // R8: one-cycle pulse, the next one a full timeout later.
        write_mode(8'h1C);
        do_refresh();
        expect_after(128, "R8 first pulse");
        expect_after(128, "R8 restart pulse");

        // R5: HALT freezes when bit 2 is clear.
        write_mode(8'h18);
        do_refresh();
        repeat (100) @(negedge clk);
        in_halt = 1'b1;
        repeat (50) @(negedge clk);
        in_halt = 1'b0;
        expect_after(28, "R5 halt frozen");

        // R5: HALT keeps counting when bit 2 is set.
        write_mode(8'h1C);
        in_halt = 1'b1;
        do_refresh();
        expect_after(128, "R5 halt running");
        in_halt = 1'b0;

        // R6: STOP freezes when bit 3 is clear.
        write_mode(8'h14);
        do_refresh();
        repeat (100) @(negedge clk);
        in_stop = 1'b1;
        repeat (50) @(negedge clk);
        in_stop = 1'b0;
        expect_after(28, "R6 stop frozen");

        // R6: STOP keeps counting when bit 3 is set.
        write_mode(8'h1C);
        in_stop = 1'b1;
        do_refresh();
        expect_after(128, "R6 stop running");
        in_stop = 1'b0;

        // R7: a refresh on the terminal edge suppresses the pulse.
        write_mode(8'h1C);
        do_refresh();
        repeat (127) @(negedge clk);
        do_refresh();
        chk(wdt_rst == 1'b0, "R7 refresh beats terminal", wdt_rst, 0);
        expect_after(128, "R7 after collision");

        // R9: a tap-changing write on the terminal edge clears the count.
        write_mode(8'h1C);
        do_refresh();
        repeat (127) @(negedge clk);
        write_mode(8'h1D);
        chk(wdt_rst == 1'b0, "R9 tap write beats terminal", wdt_rst, 0);
        expect_after(256, "R9 new tap from zero");

        // R9: a write keeping the tap does not disturb the count.
        write_mode(8'h1C);
        do_refresh();
        repeat (100) @(negedge clk);
        write_mode(8'h18);
        expect_after(27, "R9 same tap keeps count");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule